// File: doc/BRIEF.md
# Interconnect Performance Counter Unit

This block counts activity inside an interconnect so that software can measure it. It has five 32-bit counters. Counter 0 counts clock cycles. Counters 1 to 4 each count one event, picked from a flat vector of event strobes. The strobes are grouped as eight ports of 32 event codes each. Each counter has its own 4 KiB register page on a simple word-wide register bus. In that page software sets the event to count, preloads or reads the count, switches the counter on or off, and clears its overflow flag.

A counter that passes its all-ones value wraps to zero and sets a sticky flag. That flag drives the counter's own interrupt line. Software can therefore preload a count to choose a sampling period and take an interrupt when it runs out.

A separate control page holds three things: a global enable that gates every counter, a read-only field giving the number of programmable counters, and an identification register that holds a revision number. Bus reads are combinational, so `bus_rdata` is valid in the same cycle as the read request. Writes take effect at the next rising clock edge.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, every count, event selector, counter enable, overflow flag and the global enable are zero, and every bit of `irq` is low.
- R2: Counter i (0 to 4) has its page at address i*0x1000. In that page, offset 0x0 is the event selector (bits 7:0, upper bits read 0), offset 0x4 is the 32-bit count, offset 0x8 is the enable (bit 0), and offset 0xC is the overflow flag (bit 0).
- R3: A programmable counter (1 to 4) adds exactly one on each clock edge at which three things are all 1: the global enable, its own enable, and `evt_strobe[s]`. Here s is the 8-bit selector value. Bits 7:5 of the selector are the port and bits 4:0 are the code, so s = port*32 + code.
- R4: Counter 0 adds one on every clock edge at which the global enable and its own enable are both 1. Its selector is stored and read back, but it has no effect on counting.
- R5: A write to a count register loads the written value. If an increment would happen in the same cycle, the written value wins and no overflow is recorded.
- R6: An increment from 0xFFFFFFFF leaves the count at 0 and sets that counter's overflow flag. `irq[i]` is high exactly while flag i is set, starting in the cycle after the wrapping edge.
- R7: Writing 1 to bit 0 of an overflow register clears that flag. Writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R8: The control register at 0x8100 has a read/write global enable in bit 0. Its bits 15:11 read the number of programmable counters (4). The identification register at 0x8FE8 reads the revision (1) in bits 7:4. Both the read-only field and the identification register ignore writes.
- R9: A read from any address not listed in R2 or R8 returns 0. A write to such an address changes no register.
- R10: While the global enable is 0, no count changes except through a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when no read) |
| evt_strobe | input | 256 | Event pulses, bit index = port*32 + code |
| irq | output | 5 | Per-counter overflow interrupt |

## Verification
A wrong selector or enable state shows up as a count drift. That drift is visible on the next count read, and it keeps growing while events arrive. A missed or extra overflow shows up on `irq` one cycle after the wrapping edge, and it stays there because the flag is sticky. The bench keeps its own cycle-level image of every register. It compares each combinational read and the interrupt vector against that image, so a single wrong increment or a collision handled in the wrong order is caught on the first read that follows it.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int PCU_AW = 16;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_SEL,
    RK_CNT,
    RK_CTL,
    RK_OVF,
    RK_GCTL,
    RK_IDENT
  } reg_kind_e;

  // Classify a byte address into a register kind.
  function automatic reg_kind_e classify_addr(input logic [PCU_AW-1:0] a,
                                              input int num_cnt,
                                              input logic [3:0] ctrl_page);
    logic [3:0]  pg;
    logic [11:0] off;
    reg_kind_e   k;
    pg  = a[15:12];
    off = a[11:0];
    k   = RK_NONE;
    if ({28'd0, pg} < 32'(num_cnt)) begin
      case (off)
        12'h000: k = RK_SEL;
        12'h004: k = RK_CNT;
        12'h008: k = RK_CTL;
        12'h00C: k = RK_OVF;
        default: k = RK_NONE;
      endcase
    end else if (pg == ctrl_page) begin
      case (off)
        12'h100: k = RK_GCTL;
        12'hFE8: k = RK_IDENT;
        default: k = RK_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/pcu_regdec.sv
module pcu_regdec
  import pcu_pkg::*;
#(
  parameter int         NUM_CNT   = 5,
  parameter logic [3:0] CTRL_PAGE = 4'h8,
  localparam int        IW        = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [PCU_AW-1:0] bus_addr,
  output reg_kind_e         kind,
  output logic [IW-1:0]     page_idx,
  output logic              hit,
  output logic [NUM_CNT-1:0] sel_we,
  output logic [NUM_CNT-1:0] cnt_we,
  output logic [NUM_CNT-1:0] ctl_we,
  output logic [NUM_CNT-1:0] ovf_we,
  output logic              gctl_we
);

  logic wr;

  assign kind     = classify_addr(bus_addr, NUM_CNT, CTRL_PAGE);
  assign page_idx = bus_addr[12 +: IW];
  assign hit      = (kind != RK_NONE);
  assign wr       = bus_en & bus_wr;
  assign gctl_we  = wr & (kind == RK_GCTL);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_we
    logic pmatch;
    assign pmatch    = wr & (page_idx == IW'(i));
    assign sel_we[i] = pmatch & (kind == RK_SEL);
    assign cnt_we[i] = pmatch & (kind == RK_CNT);
    assign ctl_we[i] = pmatch & (kind == RK_CTL);
    assign ovf_we[i] = pmatch & (kind == RK_OVF);
  end

endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
  parameter int CW   = 32,
  parameter int SELW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gbl_en,
  input  logic            evt_hit,
  input  logic            sel_we,
  input  logic            cnt_we,
  input  logic            ctl_we,
  input  logic            ovf_we,
  input  logic [CW-1:0]   wdata,
  output logic [SELW-1:0] sel_q,
  output logic [CW-1:0]   cnt_q,
  output logic            en_q,
  output logic            ovf_q,
  output logic            inc,
  output logic            wrap
);

  function automatic logic [CW-1:0] count_next(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  function automatic logic at_top(input logic [CW-1:0] c);
    return &c;
  endfunction

  assign inc  = gbl_en & en_q & evt_hit;
  // a same-cycle preload suppresses the wrap
  assign wrap = inc & at_top(cnt_q) & ~cnt_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (sel_we) sel_q <= wdata[SELW-1:0];
      if (ctl_we) en_q  <= wdata[0];
      if (cnt_we)     cnt_q <= wdata;
      else if (inc)   cnt_q <= count_next(cnt_q);
      if (wrap)                    ovf_q <= 1'b1;
      else if (ovf_we && wdata[0]) ovf_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pcu_rdmux.sv
module pcu_rdmux
  import pcu_pkg::*;
#(
  parameter int NUM_CNT = 5,
  parameter int NUM_EVT = 4,
  parameter int CW      = 32,
  parameter int SELW    = 8,
  parameter int REV     = 1,
  localparam int IW     = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                          rd_en,
  input  reg_kind_e                     kind,
  input  logic [IW-1:0]                 page_idx,
  input  logic [NUM_CNT-1:0][SELW-1:0]  sel_q,
  input  logic [NUM_CNT-1:0][CW-1:0]    cnt_q,
  input  logic [NUM_CNT-1:0]            en_q,
  input  logic [NUM_CNT-1:0]            ovf_q,
  input  logic                          gbl_en,
  output logic [CW-1:0]                 rdata
);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (kind)
        RK_SEL:   rdata = CW'(sel_q[page_idx]);
        RK_CNT:   rdata = cnt_q[page_idx];
        RK_CTL:   rdata = CW'(en_q[page_idx]);
        RK_OVF:   rdata = CW'(ovf_q[page_idx]);
        RK_GCTL:  rdata = CW'({5'(NUM_EVT), 10'd0, gbl_en});
        RK_IDENT: rdata = CW'({4'(REV), 4'd0});
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pcu_pkg::*;
#(
  parameter int         NUM_EVT   = 4,
  parameter int         CW        = 32,
  parameter int         NUM_PORTS = 8,
  parameter int         NUM_CODES = 32,
  parameter int         REV       = 1,
  parameter logic [3:0] CTRL_PAGE = 4'h8,
  localparam int        NUM_CNT   = NUM_EVT + 1,
  localparam int        EVW       = NUM_PORTS * NUM_CODES,
  localparam int        SELW      = $clog2(EVW),
  localparam int        IW        = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_wr,
  input  logic [PCU_AW-1:0]  bus_addr,
  input  logic [CW-1:0]      bus_wdata,
  output logic [CW-1:0]      bus_rdata,
  input  logic [EVW-1:0]     evt_strobe,
  output logic [NUM_CNT-1:0] irq
);

  reg_kind_e                    kind;
  logic [IW-1:0]                page_idx;
  logic                         hit;
  logic [NUM_CNT-1:0]           sel_we, cnt_we, ctl_we, ovf_we;
  logic                         gctl_we;
  logic                         gbl_en;
  logic [NUM_CNT-1:0][SELW-1:0] sel_q;
  logic [NUM_CNT-1:0][CW-1:0]   cnt_q;
  logic [NUM_CNT-1:0]           en_q, ovf_q, evt_hit;
  // named internal events for the checker
  logic [NUM_CNT-1:0]           inc_vec, wrap_vec;

  pcu_regdec #(.NUM_CNT(NUM_CNT), .CTRL_PAGE(CTRL_PAGE)) u_dec (
    .bus_en   (bus_en),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .kind     (kind),
    .page_idx (page_idx),
    .hit      (hit),
    .sel_we   (sel_we),
    .cnt_we   (cnt_we),
    .ctl_we   (ctl_we),
    .ovf_we   (ovf_we),
    .gctl_we  (gctl_we)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       gbl_en <= 1'b0;
    else if (gctl_we) gbl_en <= bus_wdata[0];
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (i == 0) begin : g_cycle
      assign evt_hit[i] = 1'b1;
    end else begin : g_event
      assign evt_hit[i] = evt_strobe[sel_q[i]];
    end

    pcu_counter #(.CW(CW), .SELW(SELW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .gbl_en  (gbl_en),
      .evt_hit (evt_hit[i]),
      .sel_we  (sel_we[i]),
      .cnt_we  (cnt_we[i]),
      .ctl_we  (ctl_we[i]),
      .ovf_we  (ovf_we[i]),
      .wdata   (bus_wdata),
      .sel_q   (sel_q[i]),
      .cnt_q   (cnt_q[i]),
      .en_q    (en_q[i]),
      .ovf_q   (ovf_q[i]),
      .inc     (inc_vec[i]),
      .wrap    (wrap_vec[i])
    );
  end

  assign irq = ovf_q;

  pcu_rdmux #(
    .NUM_CNT(NUM_CNT), .NUM_EVT(NUM_EVT), .CW(CW), .SELW(SELW), .REV(REV)
  ) u_rd (
    .rd_en    (bus_en & ~bus_wr),
    .kind     (kind),
    .page_idx (page_idx),
    .sel_q    (sel_q),
    .cnt_q    (cnt_q),
    .en_q     (en_q),
    .ovf_q    (ovf_q),
    .gbl_en   (gbl_en),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int NUM_CNT = 5,
  parameter int CW      = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        gbl_en,
  input logic                        bus_en,
  input logic                        bus_wr,
  input logic                        hit,
  input logic [CW-1:0]               bus_wdata,
  input logic [CW-1:0]               bus_rdata,
  input logic [NUM_CNT-1:0]          cnt_we,
  input logic [NUM_CNT-1:0]          ovf_we,
  input logic [NUM_CNT-1:0]          inc_vec,
  input logic [NUM_CNT-1:0]          wrap_vec,
  input logic [NUM_CNT-1:0][CW-1:0]  cnt_q,
  input logic [NUM_CNT-1:0]          irq
);

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && !hit) |-> (bus_rdata == '0)); // R9

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we[i] |=> (cnt_q[i] == $past(bus_wdata))); // R5
    AST_INC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_vec[i] && !cnt_we[i]) |=> (cnt_q[i] == $past(cnt_q[i]) + CW'(1))); // R3
    AST_WRAP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_vec[i] |=> irq[i]); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !(ovf_we[i] && bus_wdata[0])) |=> irq[i]); // R7
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!gbl_en && !cnt_we[i]) |=> $stable(cnt_q[i])); // R10
  end

endmodule

bind perf_counter_unit pcu_checker #(.NUM_CNT(NUM_CNT), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gbl_en    (gbl_en),
  .bus_en    (bus_en),
  .bus_wr    (bus_wr),
  .hit       (hit),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .cnt_we    (cnt_we),
  .ovf_we    (ovf_we),
  .inc_vec   (inc_vec),
  .wrap_vec  (wrap_vec),
  .cnt_q     (cnt_q),
  .irq       (irq)
);

// File: tb/perf_counter_unit_tb.sv
`timescale 1ns/1ps
module perf_counter_unit_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_en = 1'b0, bus_wr = 1'b0;
  logic [15:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [255:0] evt_strobe = '0;
  logic [4:0]   irq;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0, evt_rand = 1'b0;

  always #2 clk = ~clk;

  perf_counter_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_strobe(evt_strobe), .irq(irq)
  );

  // bench image of the register state
  logic [31:0] m_cnt [5];
  logic [7:0]  m_sel [5];
  logic        m_en  [5];
  logic        m_ovf [5];
  logic        m_gen;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin
        m_cnt[i] = '0; m_sel[i] = '0; m_en[i] = 1'b0; m_ovf[i] = 1'b0;
      end
      m_gen = 1'b0;
    end else begin
      for (int i = 0; i < 5; i++) begin
        logic hit_pg, up, cw, wrp;
        hit_pg = bus_en && bus_wr && (bus_addr[15:12] == 4'(i));
        up  = m_gen && m_en[i] && (i == 0 || evt_strobe[m_sel[i]]);
        cw  = hit_pg && bus_addr[11:0] == 12'h004;
        wrp = up && (m_cnt[i] == 32'hFFFF_FFFF) && !cw;
        if (hit_pg && bus_addr[11:0] == 12'h00C && bus_wdata[0]) m_ovf[i] = 1'b0;
        if (wrp) m_ovf[i] = 1'b1;
        if (cw) m_cnt[i] = bus_wdata;
        else if (up) m_cnt[i] = m_cnt[i] + 32'd1;
        if (hit_pg && bus_addr[11:0] == 12'h000) m_sel[i] = bus_wdata[7:0];
        if (hit_pg && bus_addr[11:0] == 12'h008) m_en[i] = bus_wdata[0];
      end
      if (bus_en && bus_wr && bus_addr == 16'h8100) m_gen = bus_wdata[0];
    end
  end

  function automatic logic [31:0] exp_read(input logic [15:0] a);
    int pg;
    pg = int'(a[15:12]);
    if (pg < 5) begin
      case (a[11:0])
        12'h000: return {24'd0, m_sel[pg]};
        12'h004: return m_cnt[pg];
        12'h008: return {31'd0, m_en[pg]};
        12'h00C: return {31'd0, m_ovf[pg]};
        default: return 32'd0;
      endcase
    end
    if (a == 16'h8100) return 32'h0000_2000 | {31'd0, m_gen};
    if (a == 16'h8FE8) return 32'h0000_0010;
    return 32'd0;
  endfunction

  function automatic logic [4:0] exp_irq();
    return {m_ovf[4], m_ovf[3], m_ovf[2], m_ovf[1], m_ovf[0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  // write in the same cycle as a single event strobe
  task automatic wr_evt(input logic [15:0] a, input logic [31:0] d, input int b);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    evt_strobe = '0; evt_strobe[b] = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; evt_strobe = '0;
  endtask

  // read and compare with the bench image, plus an optional fixed value
  task automatic rd(input string req, input logic [15:0] a,
                    input bit use_fix, input logic [31:0] fix);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    check(req, bus_rdata, exp_read(a));
    if (use_fix) check(req, bus_rdata, fix);
    check({req, " irq"}, {27'd0, irq}, {27'd0, exp_irq()});
    bus_en = 1'b0;
  endtask

  task automatic pulse(input int b, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt_strobe = '0; evt_strobe[b] = 1'b1;
    end
    @(negedge clk); evt_strobe = '0;
  endtask

  always @(negedge clk) begin
    if (evt_rand)
      for (int w = 0; w < 8; w++)
        evt_strobe[w*32 +: 32] = $urandom & $urandom & $urandom;
  end

  function automatic logic [15:0] rand_addr();
    logic [3:0]  pg;
    logic [11:0] off;
    int r;
    r  = int'($urandom % 8);
    pg = (r < 6) ? 4'(r) : 4'h8;
    case ($urandom % 7)
      0: off = 12'h000;  1: off = 12'h004;  2: off = 12'h008;
      3: off = 12'h00C;  4: off = 12'h100;  5: off = 12'hFE8;
      default: off = 12'h010;
    endcase
    return {pg, off};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state, R2 map
    for (int i = 0; i < 5; i++) begin
      rd("R1 sel",  16'(i * 4096) + 16'h0, 1, 32'd0);
      rd("R1 cnt",  16'(i * 4096) + 16'h4, 1, 32'd0);
      rd("R1 en",   16'(i * 4096) + 16'h8, 1, 32'd0);
      rd("R1 ovf",  16'(i * 4096) + 16'hC, 1, 32'd0);
    end
    // R8 control and identity, read-only fields
    rd("R8 gctl", 16'h8100, 1, 32'h0000_2000);
    rd("R8 ident", 16'h8FE8, 1, 32'h0000_0010);
    wr(16'h8FE8, 32'hFFFF_FFFF);
    rd("R8 ident ro", 16'h8FE8, 1, 32'h0000_0010);
    wr(16'h8100, 32'hFFFF_FFFE);
    rd("R8 gctl ro", 16'h8100, 1, 32'h0000_2000);

    // R9 unmapped
    wr(16'h5004, 32'hDEAD_BEEF);
    wr(16'h0010, 32'h1234_5678);
    rd("R9 unmapped page", 16'h5004, 1, 32'd0);
    rd("R9 unmapped off", 16'h0010, 1, 32'd0);
    rd("R9 neighbour cnt", 16'h0004, 1, 32'd0);
    rd("R9 ctrl page hole", 16'h8104, 1, 32'd0);
    rd("R2 sel upper bits", 16'h1000, 1, 32'd0);

    // R3 programmable counter: port 5 code 3 -> bit 163
    wr(16'h1000, 32'hFFFF_FFA3);
    rd("R2 sel width", 16'h1000, 1, 32'h0000_00A3);
    wr(16'h1008, 32'd1);
    wr(16'h8100, 32'd1);
    pulse(163, 7);
    pulse(164, 3);
    pulse(3, 2);
    rd("R3 counts only selected", 16'h1004, 1, 32'd7);

    // R4 cycle counter ignores its selector
    wr(16'h0000, 32'h0000_00A3);
    wr(16'h0008, 32'd1);
    repeat (10) @(negedge clk);
    wr(16'h0008, 32'd0);
    rd("R4 cycle count", 16'h0004, 0, 32'd0);
    check("R4 cycle nonzero", {31'd0, exp_read(16'h0004) >= 32'd10}, 32'd1);

    // R6 wrap and interrupt: port 0 code 31 -> bit 31
    wr(16'h2000, 32'h0000_001F);
    wr(16'h2004, 32'hFFFF_FFFE);
    wr(16'h2008, 32'd1);
    pulse(31, 2);
    rd("R6 wrapped count", 16'h2004, 1, 32'd0);
    rd("R6 flag", 16'h200C, 1, 32'd1);
    check("R6 irq line", {27'd0, irq}, 32'h0000_0004);

    // R7 write-one-to-clear
    wr(16'h200C, 32'd0);
    rd("R7 zero keeps flag", 16'h200C, 1, 32'd1);
    wr(16'h200C, 32'd1);
    rd("R7 one clears", 16'h200C, 1, 32'd0);
    check("R7 irq low", {27'd0, irq}, 32'd0);

    // R5 write beats increment, no overflow
    wr(16'h2004, 32'hFFFF_FFFF);
    wr_evt(16'h2004, 32'h0000_1234, 31);
    rd("R5 write wins", 16'h2004, 1, 32'h0000_1234);
    rd("R5 no overflow", 16'h200C, 1, 32'd0);

    // R7 set beats clear
    wr(16'h2004, 32'hFFFF_FFFF);
    wr_evt(16'h200C, 32'd1, 31);
    rd("R7 set wins", 16'h200C, 1, 32'd1);
    wr(16'h200C, 32'd1);

    // R10 global enable off
    wr(16'h8100, 32'd0);
    pulse(163, 5);
    rd("R10 hold", 16'h1004, 1, 32'd7);

    // random phase against the bench image
    for (int i = 1; i < 5; i++) wr(16'(i * 4096) + 16'h8, 32'd1);
    wr(16'h0008, 32'd1);
    wr(16'h8100, 32'd1);
    evt_rand = 1'b1;
    repeat (3000) begin
      logic [15:0] a;
      logic [31:0] d;
      a = rand_addr();
      if ($urandom % 10 < 4) begin
        if (a[11:0] == 12'h004 && ($urandom % 2) == 1)
          d = 32'hFFFF_FFF0 | ($urandom % 16);
        else if (a == 16'h8100)
          d = {31'd0, ($urandom % 4) != 0};
        else if (a[11:0] == 12'h000)
          d = $urandom % 256;
        else
          d = $urandom;
        wr(a, d);
      end else begin
        rd("R2 R3 R4 R5 R6 R7 R9 R10 random", a, 0, 32'd0);
      end
    end
    evt_rand = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule